// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register that holds the outcomes of the most recent resolved branches. It also keeps a table of saturating counters. Each branch-address slot in the table holds one counter for every possible history value. The current history picks which of these counters answers a lookup and which one is trained when a branch resolves. Two branches that follow each other can therefore get different predictions, depending on the path that led to them.

The fetch side gives the word-address bits of a branch on the lookup port and receives a taken or not-taken guess combinationally, in the same cycle. The execution side reports each resolved branch on the update port, with its word-address bits and its actual direction. On that clock edge the selected counter moves one step toward the outcome, and the outcome is shifted into the history. The history length, the counter width and the number of address bits used for indexing are all parameters. The defaults are two history bits, two-bit counters and four index bits, which gives 64 counters.

Top module: `bpred_corr`

## Requirements
- R1: After reset the history register holds zero and every counter holds the weakly-not-taken value (binary 01 for 2-bit counters), so every lookup predicts not taken.
- R2: `predTaken` is the most significant bit of the selected counter and is valid in the same cycle as the lookup inputs, with no clock edge in between.
- R3: The table slot is chosen only by PC bits [IDX_W+1:2], which are the bits carried on the PC ports. The two alignment bits and all bits above IDX_W+1 have no influence. Two PCs that agree in bits [5:2] (default parameters) get the same prediction.
- R4: On each clock edge with `updValid` high, the history shifts left by one and `updTaken` enters at bit 0, with 1 meaning taken and 0 meaning not taken.
- R5: The counter used for a lookup or an update sits at row {pc index bits, history}, where the history is the value held before the edge. A single update changes at most that one counter.
- R6: A taken update raises the selected counter by one and holds it at the all-ones value once it gets there.
- R7: A not-taken update lowers the selected counter by one and holds it at zero once it gets there.
- R8: A counter in a strong state changes its prediction only after two opposite outcomes have trained it.
- R9: When a lookup and an update address the same counter in the same cycle, the lookup returns the value that counter had before the update.
- R10: While `updValid` is low, neither the history nor any counter changes, whatever values `updPc` and `updTaken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | IDX_W | PC bits [IDX_W+1:2] of the branch being fetched |
| predTaken | output | 1 | Predicted direction: 1 taken, 0 not taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | IDX_W | PC bits [IDX_W+1:2] of the resolved branch |
| updTaken | input | 1 | Actual direction of the resolved branch |

## Verification
On every cycle, the assertions check the history shift and its hold while no update is presented. They also check that the lookup output equals the top bit of the counter picked by address and history, that at most one counter moves per edge and none moves without an update, and that the trained counter steps by one and saturates at both ends. The reset state, the independence from the unused PC bits, the read-before-write result when lookup and update collide, and the two-miss hysteresis appear only in the bench's scenarios. In those scenarios a reference model tracks every counter and the history across directed sequences and a long random run over a small set of aliasing addresses.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  // Strobes from the control half to the counter table.
  typedef struct packed {
    logic trainEn;  // a resolved branch trains one counter this edge
    logic trainUp;  // direction of the step: 1 toward taken
  } trainStrobe_t;

endpackage

// File: rtl/bpred_ctrl.sv
module bpred_ctrl
  import bpred_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IDX_W-1:0]          lookupIdx,
  input  logic                      updValid,
  input  logic [IDX_W-1:0]          updIdx,
  input  logic                      updTaken,
  output trainStrobe_t              strb,
  output logic [IDX_W+HIST_LEN-1:0] rdRow,
  output logic [IDX_W+HIST_LEN-1:0] wrRow,
  output logic [HIST_LEN-1:0]       histQ
);

  logic [HIST_LEN-1:0] histNext;

  // The newest outcome always lands in bit 0; older ones move up.
  generate
    if (HIST_LEN == 1) begin : g_histOne
      always_comb histNext = updTaken;
    end else begin : g_histMany
      always_comb histNext = {histQ[HIST_LEN-2:0], updTaken};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (updValid) begin
      histQ <= histNext;
    end
  end

  // Both ports read the history as it stands before the edge.
  always_comb begin
    rdRow        = {lookupIdx, histQ};
    wrRow        = {updIdx, histQ};
    strb.trainEn = updValid;
    strb.trainUp = updTaken;
  end

endmodule

// File: rtl/bpred_satctr.sv
module bpred_satctr #(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic             stepUp,
  output logic [CTR_W-1:0] ctrQ
);

  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrQ <= CTR_INIT;
    end else if (stepEn) begin
      if (stepUp) begin
        if (ctrQ != CTR_MAX) ctrQ <= ctrQ + 1'b1;
      end else begin
        if (ctrQ != '0) ctrQ <= ctrQ - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bpred_table.sv
module bpred_table
  import bpred_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int CTR_W = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  trainStrobe_t                   strb,
  input  logic [ROW_W-1:0]               rdRow,
  input  logic [ROW_W-1:0]               wrRow,
  output logic                           predTaken,
  output logic [(1<<ROW_W)*CTR_W-1:0]    ctrFlat
);

  localparam int NUM_ROW = 1 << ROW_W;

  logic [CTR_W-1:0] ctrArr [NUM_ROW];
  logic [CTR_W-1:0] rdVal;

  generate
    for (genvar i = 0; i < NUM_ROW; i++) begin : g_row
      logic hitWr;
      assign hitWr = strb.trainEn && (wrRow == ROW_W'(i));

      bpred_satctr #(.CTR_W(CTR_W)) ctrI (
        .clk    (clk),
        .rstN   (rstN),
        .stepEn (hitWr),
        .stepUp (strb.trainUp),
        .ctrQ   (ctrArr[i])
      );

      assign ctrFlat[i*CTR_W +: CTR_W] = ctrArr[i];
    end
  endgenerate

  // Combinational read of registered state: a same-cycle write is not seen.
  always_comb begin
    rdVal     = ctrArr[rdRow];
    predTaken = rdVal[CTR_W-1];
  end

endmodule

// File: rtl/bpred_corr.sv
module bpred_corr
  import bpred_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 2,
  parameter int CTR_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W+1:2]   lookupPc,
  output logic               predTaken,
  input  logic               updValid,
  input  logic [IDX_W+1:2]   updPc,
  input  logic               updTaken
);

  localparam int ROW_W   = IDX_W + HIST_LEN;
  localparam int NUM_ROW = 1 << ROW_W;

  trainStrobe_t               strb;
  logic [ROW_W-1:0]           rdRow;
  logic [ROW_W-1:0]           wrRow;
  logic [HIST_LEN-1:0]        histQ;
  logic [NUM_ROW*CTR_W-1:0]   ctrFlat;

  bpred_ctrl #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .lookupIdx (lookupPc),
    .updValid  (updValid),
    .updIdx    (updPc),
    .updTaken  (updTaken),
    .strb      (strb),
    .rdRow     (rdRow),
    .wrRow     (wrRow),
    .histQ     (histQ)
  );

  bpred_table #(.ROW_W(ROW_W), .CTR_W(CTR_W)) tableI (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdRow     (rdRow),
    .wrRow     (wrRow),
    .predTaken (predTaken),
    .ctrFlat   (ctrFlat)
  );

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 2,
  parameter int CTR_W    = 2
) (
  input logic                                      clk,
  input logic                                      rstN,
  input logic [IDX_W-1:0]                          lookupIdx,
  input logic                                      updValid,
  input logic [IDX_W-1:0]                          updIdx,
  input logic                                      updTaken,
  input logic                                      predTaken,
  input logic [HIST_LEN-1:0]                       histQ,
  input logic [(1<<(IDX_W+HIST_LEN))*CTR_W-1:0]    ctrFlat
);

  localparam int ROW_W   = IDX_W + HIST_LEN;
  localparam int NUM_ROW = 1 << ROW_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [HIST_LEN:0]        shiftWide;
  logic                     lkBit;
  logic [NUM_ROW*CTR_W-1:0] prevFlat;
  logic                     primed;
  logic [NUM_ROW-1:0]       changedMask;
  logic [ROW_W-1:0]         selQ;
  logic                     validQ;
  logic                     takenQ;
  logic [CTR_W-1:0]         selPrevQ;
  logic [CTR_W-1:0]         selNow;
  logic [CTR_W-1:0]         selBefore;

  always_comb begin
    shiftWide = {histQ, updTaken};
    lkBit     = ctrFlat[int'({lookupIdx, histQ})*CTR_W + CTR_W-1];
    selBefore = ctrFlat[int'({updIdx, histQ})*CTR_W +: CTR_W];
    selNow    = ctrFlat[int'(selQ)*CTR_W +: CTR_W];
    for (int i = 0; i < NUM_ROW; i++) begin
      changedMask[i] = (ctrFlat[i*CTR_W +: CTR_W] != prevFlat[i*CTR_W +: CTR_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFlat <= '0;
      primed   <= 1'b0;
      selQ     <= '0;
      validQ   <= 1'b0;
      takenQ   <= 1'b0;
      selPrevQ <= '0;
    end else begin
      prevFlat <= ctrFlat;
      primed   <= 1'b1;
      selQ     <= {updIdx, histQ};
      validQ   <= updValid;
      takenQ   <= updTaken;
      selPrevQ <= selBefore;
    end
  end

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histQ == $past(shiftWide[HIST_LEN-1:0]));

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));

  // R10
  no_train_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !validQ) |-> changedMask == '0);

  // R5
  one_ctr_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> $countones(changedMask) <= 1);

  // R2
  pred_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    predTaken == lkBit);

  // R6
  sat_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && takenQ) |-> selNow == ((selPrevQ == CTR_MAX) ? CTR_MAX : selPrevQ + 1'b1));

  // R7
  sat_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !takenQ) |-> selNow == ((selPrevQ == '0) ? '0 : selPrevQ - 1'b1));

endmodule

bind bpred_corr bpred_chk #(
  .IDX_W    (IDX_W),
  .HIST_LEN (HIST_LEN),
  .CTR_W    (CTR_W)
) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .lookupIdx (lookupPc),
  .updValid  (updValid),
  .updIdx    (updPc),
  .updTaken  (updTaken),
  .predTaken (predTaken),
  .histQ     (histQ),
  .ctrFlat   (ctrFlat)
);

// File: tb/bpred_corr_test.sv
`timescale 1ns/1ps
module bpred_corr_test;

  localparam int IDX_W    = 4;
  localparam int HIST_LEN = 2;
  localparam int CTR_W    = 2;
  localparam int NUM_ROW  = 1 << (IDX_W + HIST_LEN);
  localparam int CMAX     = (1 << CTR_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkPcFull = '0;
  logic [31:0] upPcFull = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic        predTaken;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  int mCtr [NUM_ROW];
  int mHist;

  always #4 clk = ~clk;

  bpred_corr #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN), .CTR_W(CTR_W)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .lookupPc  (lkPcFull[IDX_W+1:2]),
    .predTaken (predTaken),
    .updValid  (updValid),
    .updPc     (upPcFull[IDX_W+1:2]),
    .updTaken  (updTaken)
  );

  function automatic int rowOf(logic [31:0] pc);
    return (int'(pc[IDX_W+1:2]) << HIST_LEN) | mHist;
  endfunction

  function automatic bit expPred(logic [31:0] pc);
    return mCtr[rowOf(pc)] >= (1 << (CTR_W-1));
  endfunction

  function automatic void modelTrain(logic [31:0] pc, bit t);
    int r = rowOf(pc);
    if (t) begin
      if (mCtr[r] < CMAX) mCtr[r]++;
    end else begin
      if (mCtr[r] > 0) mCtr[r]--;
    end
    mHist = ((mHist << 1) | int'(t)) & ((1 << HIST_LEN) - 1);
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < NUM_ROW; i++) mCtr[i] = (1 << (CTR_W-1)) - 1;
    mHist = 0;
  endfunction

  task automatic checkBit(string tag, bit act, bit exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: predTaken=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle, check the lookup before the edge, then advance the model.
  task automatic step(logic [31:0] lpc, bit v, logic [31:0] upc, bit t, string tag);
    @(negedge clk);
    lkPcFull = lpc;
    updValid = v;
    upPcFull = upc;
    updTaken = t;
    #1;
    checkBit(tag, predTaken, expPred(lpc));
    @(posedge clk);
    if (v) modelTrain(upc, t);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  logic [31:0] pool [6];

  initial begin
    void'($urandom(32'd2718));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every slot predicts not taken out of reset
    for (int i = 0; i < (1 << IDX_W); i++) begin
      step(32'(i) << 2, 1'b0, '0, 1'b0, "R1 reset");
      checkBit("R1 reset value", predTaken, 1'b0);
    end

    // R10: garbage on update inputs while updValid is low changes nothing
    for (int i = 0; i < 8; i++) begin
      step(32'h0000_0010, 1'b0, 32'h0000_0010, 1'b1, "R10 idle");
    end
    checkBit("R10 no training", predTaken, 1'b0);

    // R6 R9: taken stream on one branch; lookup collides with the update
    for (int i = 0; i < 6; i++) begin
      step(32'h0000_0010, 1'b1, 32'h0000_0010, 1'b1, "R9 same slot");
    end
    // history now 11; counter {4,11} saturated at 11
    step(32'h0000_0010, 1'b0, '0, 1'b0, "R6 saturate up");
    checkBit("R6 strong taken", predTaken, 1'b1);

    // R3: same bits [5:2], different alignment and upper bits
    step(32'h0000_0013, 1'b0, '0, 1'b0, "R3 low bits");
    checkBit("R3 low bits", predTaken, 1'b1);
    step(32'hABCD_EF10, 1'b0, '0, 1'b0, "R3 high bits");
    checkBit("R3 high bits", predTaken, 1'b1);
    step(32'h0000_0014, 1'b0, '0, 1'b0, "R3 other slot");
    checkBit("R3 other slot", predTaken, 1'b0);

    // R4 R5: history selects a different counter for the same branch
    step(32'h0000_0020, 1'b1, 32'h0000_0020, 1'b0, "R4 shift");
    // history now 10: slot 4 row 10 untouched -> not taken
    step(32'h0000_0010, 1'b0, '0, 1'b0, "R5 history select");
    checkBit("R5 history select", predTaken, 1'b0);

    // R7 R8: strong not-taken on a fresh slot with history held at 00
    for (int i = 0; i < 3; i++) step(32'h0000_0008, 1'b1, 32'h0000_0030, 1'b0, "R7 drive");
    for (int i = 0; i < 4; i++) step(32'h0000_0008, 1'b1, 32'h0000_0008, 1'b0, "R7 saturate down");
    checkBit("R7 strong not taken", predTaken, 1'b0);
    // first taken outcome: counter 00 -> 01, still not taken
    step(32'h0000_0008, 1'b1, 32'h0000_0008, 1'b1, "R8 first miss");
    // history now 01; pull it back to 00 through another slot
    step(32'h0000_0008, 1'b1, 32'h0000_003C, 1'b0, "R8 realign");
    step(32'h0000_0008, 1'b1, 32'h0000_003C, 1'b0, "R8 realign");
    step(32'h0000_0008, 1'b0, '0, 1'b0, "R8 one miss");
    checkBit("R8 one miss keeps", predTaken, 1'b0);
    step(32'h0000_0008, 1'b1, 32'h0000_0008, 1'b1, "R8 second miss");
    step(32'h0000_0008, 1'b1, 32'h0000_003C, 1'b0, "R8 realign");
    step(32'h0000_0008, 1'b1, 32'h0000_003C, 1'b0, "R8 realign");
    step(32'h0000_0008, 1'b0, '0, 1'b0, "R8 two misses");
    checkBit("R8 two misses flip", predTaken, 1'b1);

    // R2 R4 R5 R9: random traffic on aliasing addresses
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1004;
    pool[2] = 32'h8000_1000; pool[3] = 32'h0000_103C;
    pool[4] = 32'h0000_1022; pool[5] = 32'hFFFF_FFF8;
    for (int i = 0; i < 4000; i++) begin
      int li = $urandom_range(0, 5);
      int ui = $urandom_range(0, 5);
      bit v  = ($urandom_range(0, 9) < 7);
      bit t  = (ui < 3) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 3);
      if (ui == 3) t = mHist[0] ^ 1'b1;
      step(pool[li], v, pool[ui], t, "R2 R5 random");
    end

    finishRun();
  end

endmodule